// File: doc/BRIEF.md
# Subaddressed I2C Control Register Slave

This block is an I2C slave that answers at one fixed 7-bit address and holds six 8-bit control registers. These registers set speaker volumes, headphone volume, tone settings and two switch words. A host writes to the block with transactions in which every data byte has its own subaddress byte in front of it. There is no automatic advance of the subaddress. A new pair, which may name any register, can follow in the same transaction.

A read transaction returns one status byte. The byte is assembled from two decoder flags and three test bits. It is latched when the read address is acknowledged. A read is accepted only after a stop and a fresh start. A read address sent after a repeated start is refused.

Both bus lines are brought into the system clock domain through a synchroniser and a stability filter. Start and stop detection works on the filtered lines. The data line is driven only low, through an output-enable.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 1000010, so 0x84 for a write and 0x85 for a read. It does not acknowledge any other address, and it ignores every following byte until the next start.
- R2: In a write, a subaddress byte followed by a data byte loads the data into the register selected by the subaddress. The subaddresses are 0x01 for left speaker volume, 0x02 for right speaker volume, 0x03 for headphone volume, 0x05 for tone and 0x07 and 0x00 for the two switch words.
- R3: A single write transaction may hold several pairs, and their subaddresses may come in any order.
- R4: The byte that follows a data byte is always taken as a new subaddress. A data byte sent without its own subaddress therefore never writes a register.
- R5: A subaddress outside the map is acknowledged, and the data byte that follows it changes no register.
- R6: A stop between a subaddress and its data byte discards that subaddress. The next byte after a new address is then a subaddress.
- R7: A read returns, MSB first, the byte {decoder flags[1:0], test bits[2:0], 3'b000}, sampled when the read address is acknowledged.
- R8: A read address sent after a repeated start, with no stop before it, is not acknowledged.
- R9: A pulse on either line that is shorter than FILT_LEN system clocks after synchronisation is suppressed. It causes no start, no stop and no bit change.
- R10: The data-line enable changes only while the filtered clock line is low. It is released after every acknowledge slot and after the last read bit.
- R11: After reset, every register reads 0x00 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (as seen on the wire) |
| sda_oe_o | output | 1 | When 1, pull the data line low |
| dec_flags_i | input | 2 | Decoder flags (bit 1 stereo, bit 0 dual) |
| test_bits_i | input | 3 | Test bits placed in the status byte |
| spk_vol_l_o | output | 8 | Left speaker volume register |
| spk_vol_r_o | output | 8 | Right speaker volume register |
| hp_vol_o | output | 8 | Headphone volume register |
| tone_o | output | 8 | Treble/bass register |
| switch_a_o | output | 8 | First switch word |
| switch_b_o | output | 8 | Second switch word |

## Verification
The hardest case to reach from the ports is a spurious start-then-stop pair. The filter must hide it while the bus clock is high in the middle of a data bit. The bench produces it by pulling the data line low for two system clocks during the high phase of a 1 bit. It then checks that the pair still writes its register. Byte-alignment slips are reached in a similar way. The bench sends three bytes after one subaddress, and it also sends a stop between a subaddress and its data byte. It then checks that no register takes a stray value.

// File: rtl/i2c_ctrl_pkg.sv
package i2c_ctrl_pkg;
  localparam int N_CTRL = 6;
  localparam int DW     = 8;
  // index: 0 spk_l, 1 spk_r, 2 hp, 3 tone, 4 switch_a, 5 switch_b
  localparam logic [DW-1:0] SUB_MAP [N_CTRL] = '{8'h01, 8'h02, 8'h03, 8'h05, 8'h07, 8'h00};

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_RECV,
    BUS_ACK,
    BUS_SEND
  } bus_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  localparam int CW = $clog2(FILT_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   samp;

  assign samp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      run_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      if (samp == line_o) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        line_o <= samp;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000010
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_i,
  input  logic [DW-1:0] status_i,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_sub_o,
  output logic [DW-1:0] wr_data_o,
  output logic          pair_open_o
);
  bus_state_e    state_q;
  logic [3:0]    cnt_q;
  logic [DW-1:0] rx_q, tx_q, sub_q;
  logic          addr_ph_q, rd_q, fresh_q, want_sub_q;

  assign wr_sub_o    = sub_q;
  assign wr_data_o   = rx_q;
  assign pair_open_o = want_sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= BUS_IDLE;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      sub_q      <= '0;
      addr_ph_q  <= 1'b0;
      rd_q       <= 1'b0;
      fresh_q    <= 1'b1;
      want_sub_q <= 1'b1;
      sda_oe_o   <= 1'b0;
      wr_en_o    <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q    <= BUS_RECV;
        cnt_q      <= '0;
        addr_ph_q  <= 1'b1;
        rd_q       <= 1'b0;
        want_sub_q <= 1'b1;
        sda_oe_o   <= 1'b0;
      end else if (stop_i) begin
        state_q    <= BUS_IDLE;
        want_sub_q <= 1'b1;
        fresh_q    <= 1'b1;
        sda_oe_o   <= 1'b0;
      end else begin
        unique case (state_q)
          BUS_RECV: begin
            if (scl_rise_i && cnt_q != 4'd8) begin
              rx_q  <= {rx_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (addr_ph_q) begin
                fresh_q <= 1'b0;
                // read only allowed straight after a stop
                if (rx_q[7:1] == DEV_ADDR && !(rx_q[0] && !fresh_q)) begin
                  sda_oe_o <= 1'b1;
                  state_q  <= BUS_ACK;
                  rd_q     <= rx_q[0];
                  tx_q     <= status_i;
                end else begin
                  state_q <= BUS_IDLE;
                end
              end else begin
                sda_oe_o <= 1'b1;
                state_q  <= BUS_ACK;
                if (want_sub_q) begin
                  sub_q      <= rx_q;
                  want_sub_q <= 1'b0;
                end else begin
                  wr_en_o    <= 1'b1;
                  want_sub_q <= 1'b1;
                end
              end
            end
          end
          BUS_ACK: begin
            if (scl_fall_i) begin
              cnt_q     <= '0;
              addr_ph_q <= 1'b0;
              if (rd_q) begin
                state_q  <= BUS_SEND;
                sda_oe_o <= ~tx_q[7];
              end else begin
                state_q  <= BUS_RECV;
                sda_oe_o <= 1'b0;
              end
            end
          end
          BUS_SEND: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                state_q  <= BUS_IDLE;
              end else begin
                tx_q     <= {tx_q[DW-2:0], 1'b0};
                sda_oe_o <= ~tx_q[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import i2c_ctrl_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [DW-1:0]            wr_sub_i,
  input  logic [DW-1:0]            wr_data_i,
  output logic [N_CTRL-1:0][DW-1:0] regs_o
);
  for (genvar i = 0; i < N_CTRL; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_o[i] <= '0;
      else if (wr_en_i && wr_sub_i == SUB_MAP[i]) regs_o[i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave
  import i2c_ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000010,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] dec_flags_i,
  input  logic [2:0] test_bits_i,
  output logic [7:0] spk_vol_l_o,
  output logic [7:0] spk_vol_r_o,
  output logic [7:0] hp_vol_o,
  output logic [7:0] tone_o,
  output logic [7:0] switch_a_o,
  output logic [7:0] switch_b_o
);
  logic [1:0] raw, filt;
  logic       scl_f, sda_f, scl_q, sda_q;
  logic       start_det, stop_det, scl_rise, scl_fall;
  logic       wr_en, pair_open;
  logic [DW-1:0] wr_sub, wr_data;
  logic [N_CTRL-1:0][DW-1:0] regs;

  assign raw = {sda_i, scl_i};

  for (genvar i = 0; i < 2; i++) begin : g_line
    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[i]),
      .line_o(filt[i])
    );
  end

  assign scl_f = filt[0];
  assign sda_f = filt[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_det = scl_f && scl_q && sda_q && !sda_f;
  assign stop_det  = scl_f && scl_q && !sda_q && sda_f;
  assign scl_rise  = scl_f && !scl_q;
  assign scl_fall  = !scl_f && scl_q;

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_f),
    .status_i   ({dec_flags_i, test_bits_i, 3'b000}),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_sub_o   (wr_sub),
    .wr_data_o  (wr_data),
    .pair_open_o(pair_open)
  );

  ctrl_reg_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_sub_i (wr_sub),
    .wr_data_i(wr_data),
    .regs_o   (regs)
  );

  assign spk_vol_l_o = regs[0];
  assign spk_vol_r_o = regs[1];
  assign hp_vol_o    = regs[2];
  assign tone_o      = regs[3];
  assign switch_a_o  = regs[4];
  assign switch_b_o  = regs[5];
endmodule

// File: rtl/i2c_ctrl_slave_chk.sv
module i2c_ctrl_slave_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_f_i,
  input logic        sda_oe_i,
  input logic        stop_i,
  input logic        wr_en_i,
  input logic        pair_open_i,
  input logic [47:0] regs_i
);
  // R10
  oe_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_f_i);

  // R2
  one_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!$stable(regs_i[7:0]), !$stable(regs_i[15:8]), !$stable(regs_i[23:16]),
                !$stable(regs_i[31:24]), !$stable(regs_i[39:32]), !$stable(regs_i[47:40])}) <= 1);

  // R5
  write_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_i) |-> $past(wr_en_i));

  // R4
  realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> pair_open_i);

  // R6
  stop_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> pair_open_i);
endmodule

bind i2c_ctrl_slave i2c_ctrl_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_f_i    (scl_f),
  .sda_oe_i   (sda_oe_o),
  .stop_i     (stop_det),
  .wr_en_i    (wr_en),
  .pair_open_i(pair_open),
  .regs_i     ({switch_b_o, switch_a_o, tone_o, hp_vol_o, spk_vol_r_o, spk_vol_l_o})
);

// File: tb/sim_i2c_ctrl_slave.sv
module sim_i2c_ctrl_slave;
  localparam int Q = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [1:0] flags = 2'b00;
  logic [2:0] tbits = 3'b000;
  logic [7:0] spk_l, spk_r, hp, tone, sw_a, sw_b;
  wire  sda_w = sda_m & ~sda_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_ctrl_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_w), .sda_oe_o(sda_oe),
    .dec_flags_i(flags), .test_bits_i(tbits),
    .spk_vol_l_o(spk_l), .spk_vol_r_o(spk_r), .hp_vol_o(hp), .tone_o(tone),
    .switch_a_o(sw_a), .switch_b_o(sw_b)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack, input bit glitch = 1'b0);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq();
      if (glitch && i == 7) begin
        sda_m = 1'b0; repeat (2) @(negedge clk); sda_m = 1'b1;
      end
      wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_w; wq(); scl = 1'b0; wq();
  endtask

  task automatic rbyte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_w; wq(); scl = 1'b0; wq();
    end
    wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
  endtask

  task automatic chk_all(input string req, input logic [47:0] e);
    chk(req, spk_l, e[47:40]); chk(req, spk_r, e[39:32]); chk(req, hp, e[31:24]);
    chk(req, tone, e[23:16]);  chk(req, sw_a, e[15:8]);   chk(req, sw_b, e[7:0]);
  endtask

  task automatic t_reset();
    chk_all("R11 reset regs", 48'h0);
    chk("R11 sda released", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_pairs();
    logic a;
    logic [7:0] seq [13] = '{8'h84, 8'h01, 8'h3F, 8'h02, 8'h2A, 8'h03, 8'h11,
                              8'h05, 8'h88, 8'h07, 8'hC8, 8'h00, 8'h01};
    bstart();
    foreach (seq[i]) begin
      wbyte(seq[i], a);
      chk("R1 R2 ack", {7'd0, a}, 8'h01);
    end
    bstop();
    chk_all("R2 register map", 48'h3F2A1188C801);
    chk("R10 released after stop", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_order();
    logic a;
    bstart(); wbyte(8'h84, a); wbyte(8'h00, a); wbyte(8'h5A, a);
    wbyte(8'h05, a); wbyte(8'h77, a); bstop();
    chk_all("R3 reverse order", 48'h3F2A1177C85A);
  endtask

  task automatic t_nopair();
    logic a;
    bstart(); wbyte(8'h84, a); wbyte(8'h03, a); wbyte(8'h08, a);
    wbyte(8'h09, a); wbyte(8'h0A, a); bstop();
    chk_all("R4 bare data bytes", 48'h3F2A0877C85A);
  endtask

  task automatic t_unknown();
    logic a;
    bstart(); wbyte(8'h84, a); wbyte(8'h04, a);
    chk("R5 unknown sub ack", {7'd0, a}, 8'h01);
    wbyte(8'hFF, a);
    chk("R5 unknown data ack", {7'd0, a}, 8'h01);
    wbyte(8'h06, a); wbyte(8'hEE, a); bstop();
    chk_all("R5 unknown discarded", 48'h3F2A0877C85A);
  endtask

  task automatic t_stopmid();
    logic a;
    bstart(); wbyte(8'h84, a); wbyte(8'h01, a); bstop();
    bstart(); wbyte(8'h84, a); wbyte(8'h3C, a); bstop();
    chk("R6 pending sub dropped", spk_l, 8'h3F);
  endtask

  task automatic t_badaddr();
    logic a;
    bstart(); wbyte(8'h86, a);
    chk("R1 foreign address nack", {7'd0, a}, 8'h00);
    wbyte(8'h01, a);
    chk("R1 ignored byte nack", {7'd0, a}, 8'h00);
    wbyte(8'h00, a); bstop();
    chk("R1 no write after nack", spk_l, 8'h3F);
  endtask

  task automatic t_read(input logic [1:0] f, input logic [2:0] t, input logic [7:0] exp);
    logic a;
    logic [7:0] b;
    flags = f; tbits = t;
    bstart(); wbyte(8'h85, a);
    chk("R1 read address ack", {7'd0, a}, 8'h01);
    rbyte(b);
    chk("R7 status byte", b, exp);
    chk("R10 released after read", {7'd0, sda_oe}, 8'h00);
    bstop();
  endtask

  task automatic t_rpt_start();
    logic a;
    bstart(); wbyte(8'h84, a); wbyte(8'h07, a); wbyte(8'h48, a);
    bstart(); wbyte(8'h85, a);
    chk("R8 read after repeated start", {7'd0, a}, 8'h00);
    bstop();
    chk("R8 write before it applied", sw_a, 8'h48);
  endtask

  task automatic t_glitch();
    logic a;
    bstart(); wbyte(8'h84, a); wbyte(8'h02, a);
    wbyte(8'h99, a, 1'b1);
    chk("R9 glitch ack", {7'd0, a}, 8'h01);
    bstop();
    chk("R9 glitch suppressed", spk_r, 8'h99);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_pairs();
    t_order();
    t_nopair();
    t_unknown();
    t_stopmid();
    t_badaddr();
    t_read(2'b10, 3'b101, 8'hA8);
    t_read(2'b01, 3'b010, 8'h50);
    t_rpt_start();
    t_glitch();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule